// File: doc/BRIEF.md
# Non-Restoring Division Step Sequencer

This block performs binary long division one bit per clock using the non-restoring method. Each step shifts a partial remainder left by one, feeding the running T flag into the vacated low bit, then either subtracts or adds the divisor. The choice depends on whether the previous quotient flag Q agrees with the divisor sign flag M. The carry or borrow of that operation rebuilds Q, and T reports whether the new Q matches M. Over the steps, T carries the successive quotient bits into the low end of the remainder register.

A small sequencer repeats the step a programmed number of times, at most `DATA_W`, after a single start strobe. The caller loads the divisor, the remainder, and the three flags together with the start. The caller is also responsible for any sign preparation of the flags and for any signed correction of the final result. When the last step is written, a one-cycle done pulse marks the result. For an unsigned divide of a dividend by a half-width divisor, the caller places the divisor in the upper half, clears all flags and runs half-width steps. The quotient is then the low half of the remainder shifted left once with the final T in bit 0.

Top module: `divstep_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `rem_out`, `q_out`, `t_out`, `busy` and `done` all become 0.
- R2: In each step, the interim Q is bit `DATA_W-1` of the partial remainder. The remainder is then shifted left by one, with the current T entering at bit 0.
- R3: In each step, the divisor is subtracted from the shifted value when the previous Q equals M, and added otherwise. Modulo 2^`DATA_W` this sum or difference becomes the new remainder. The flag is a borrow for a subtraction and a carry for an addition.
- R4: The new Q depends on the previous Q and on M. For 00 and 10 it is the interim Q XOR the flag. For 01 and 11 it is the inverse of that XOR.
- R5: After every step, `t_out` is 1 exactly when the new Q equals M.
- R6: A start accepted with a count N > 0 loads the operands and sets `busy`. Exactly one step is then applied on each of the next N clock edges. `busy` falls, and `done` is high for one cycle, on the edge that writes the last step.
- R7: A `start` seen while `busy` is high is ignored. The running operation and its operands are unaffected.
- R8: A start with a count of 0 loads the operands, applies no step, and raises `done` for one cycle on the next edge without setting `busy`.
- R9: Starting from Q = M = T = 0, with the divisor in the upper half and the dividend's upper half below it, `DATA_W/2` steps leave the quotient as `((rem_out << 1) | t_out)` masked to `DATA_W/2` bits.
- R10: A count above `DATA_W` is treated as `DATA_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, honoured only while idle |
| step_count | input | CNT_W | Number of steps to run |
| divisor | input | DATA_W | Divisor operand loaded at start |
| rem_in | input | DATA_W | Initial partial remainder / dividend |
| m_in | input | 1 | Divisor sign flag M |
| q_in | input | 1 | Initial quotient flag Q |
| t_in | input | 1 | Initial T flag |
| rem_out | output | DATA_W | Registered partial remainder |
| q_out | output | 1 | Registered Q flag |
| t_out | output | 1 | Registered T flag |
| busy | output | 1 | High while steps remain |
| done | output | 1 | One-cycle pulse when the run ends |

## Verification
The bench builds the block with the default `DATA_W = 32`, which gives a 6-bit count field. At that width, a count of 40 exercises the clamp to 32, and full 32-step chains run with arbitrary flag combinations. All four (Q, M) cases occur, so both add and subtract paths and their carry and borrow flags are compared against a behavioural model on every clock. The half width of 16 bits allows the quotient extraction to be checked against integer division, including dividends just under the divisor-shifted limit.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  // Flag pair produced by one division step
  typedef struct packed {
    logic q;
    logic t;
  } step_flags_t;

  // Operation selected by a step
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } step_op_t;
endpackage

// File: rtl/divstep_core.sv
module divstep_core
  import divstep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rem_i,
  input  logic [DATA_W-1:0] dvs_i,
  input  logic              q_i,
  input  logic              m_i,
  input  logic              t_i,
  output logic [DATA_W-1:0] rem_o,
  output step_flags_t       flags_o
);
  localparam int EXT_W = DATA_W + 1;

  logic              iq;
  logic [DATA_W-1:0] shifted;
  logic [EXT_W-1:0]  wide;
  logic              flag;
  step_op_t          op;
  logic              nq;

  always_comb begin
    iq      = rem_i[DATA_W-1];
    shifted = {rem_i[DATA_W-2:0], t_i};
    op      = (q_i == m_i) ? OP_SUB : OP_ADD;
    if (op == OP_SUB)
      wide = {1'b0, shifted} - {1'b0, dvs_i};
    else
      wide = {1'b0, shifted} + {1'b0, dvs_i};
    // bit DATA_W is the borrow of a subtraction or the carry of an addition
    flag  = wide[DATA_W];
    rem_o = wide[DATA_W-1:0];
    unique case ({q_i, m_i})
      2'b00:   nq = iq ^ flag;
      2'b01:   nq = ~(iq ^ flag);
      2'b10:   nq = iq ^ flag;
      default: nq = ~(iq ^ flag);
    endcase
    flags_o.q = nq;
    flags_o.t = (nq == m_i);
  end
endmodule

// File: rtl/divstep_seq.sv
module divstep_seq #(
  parameter int MAX_STEPS = 32,
  parameter int CNT_W     = $clog2(MAX_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count_i,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_STEPS);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] req;

  always_comb begin
    load_o = start && !busy_o;
    step_o = busy_o;
    req    = (count_i > LIMIT) ? LIMIT : count_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (start) begin
        left_q <= req;
        if (req == '0) done_o <= 1'b1;
        else           busy_o <= 1'b1;
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && left_q > CNT_W'(1)) |=> (busy_o && left_q == $past(left_q) - 1'b1));
  assert_clamp_R10: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (left_q <= LIMIT));
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  step_count,
  input  logic [DATA_W-1:0] divisor,
  input  logic [DATA_W-1:0] rem_in,
  input  logic              m_in,
  input  logic              q_in,
  input  logic              t_in,
  output logic [DATA_W-1:0] rem_out,
  output logic              q_out,
  output logic              t_out,
  output logic              busy,
  output logic              done
);
  logic              load;
  logic              step;
  logic              m_q;
  logic [DATA_W-1:0] dvs_q;
  logic [DATA_W-1:0] rem_next;
  step_flags_t       fl_next;

  divstep_seq #(.MAX_STEPS(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .count_i(step_count),
    .load_o(load), .step_o(step), .busy_o(busy), .done_o(done)
  );

  divstep_core #(.DATA_W(DATA_W)) u_core (
    .rem_i(rem_out), .dvs_i(dvs_q), .q_i(q_out), .m_i(m_q), .t_i(t_out),
    .rem_o(rem_next), .flags_o(fl_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_out <= '0;
      dvs_q   <= '0;
      q_out   <= 1'b0;
      t_out   <= 1'b0;
      m_q     <= 1'b0;
    end else if (load) begin
      rem_out <= rem_in;
      dvs_q   <= divisor;
      q_out   <= q_in;
      t_out   <= t_in;
      m_q     <= m_in;
    end else if (step) begin
      rem_out <= rem_next;
      q_out   <= fl_next.q;
      t_out   <= fl_next.t;
    end
  end

  assert_t_tracks_q_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (t_out == (q_out == m_q)));
  assert_no_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(m_q) && $stable(dvs_q)));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(rem_out) && $stable(q_out) && $stable(t_out)));
endmodule

// File: tb/tb_divstep_unit.sv
module tb_divstep_unit;
  localparam int DW = 32;
  localparam int CW = $clog2(DW + 1);
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] step_count = '0;
  logic [DW-1:0] divisor = '0, rem_in = '0;
  logic m_in = 0, q_in = 0, t_in = 0;
  logic [DW-1:0] rem_out;
  logic q_out, t_out, busy, done;

  int tests = 0;
  int fails = 0;
  bit running = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divstep_unit #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .step_count(step_count),
    .divisor(divisor), .rem_in(rem_in), .m_in(m_in), .q_in(q_in), .t_in(t_in),
    .rem_out(rem_out), .q_out(q_out), .t_out(t_out), .busy(busy), .done(done)
  );

  // behavioural reference state
  logic [DW-1:0] e_rem, e_dvs;
  bit e_q, e_t, e_m, e_busy, e_done;
  int e_left;

  task automatic ref_step();
    logic [DW-1:0] sh, res;
    bit iq, fl, nq;
    iq = e_rem[DW-1];
    sh = (e_rem << 1) | DW'(e_t);
    if (e_q == e_m) begin res = sh - e_dvs; fl = (res > sh); end
    else            begin res = sh + e_dvs; fl = (res < sh); end
    case ({e_q, e_m})
      2'b00: nq = iq ^ fl;
      2'b01: nq = !(iq ^ fl);
      2'b10: nq = iq ^ fl;
      default: nq = !(iq ^ fl);
    endcase
    e_rem = res;
    e_q = nq;
    e_t = (nq == e_m);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      e_rem = '0; e_dvs = '0; e_q = 0; e_t = 0; e_m = 0;
      e_busy = 0; e_done = 0; e_left = 0;
    end else begin
      e_done = 0;
      if (e_busy) begin
        ref_step();
        e_left = e_left - 1;
        if (e_left == 0) begin e_busy = 0; e_done = 1; end
      end else if (start) begin
        e_rem = rem_in; e_dvs = divisor; e_q = q_in; e_t = t_in; e_m = m_in;
        e_left = (int'(step_count) > DW) ? DW : int'(step_count);  // R10 clamp
        if (e_left == 0) e_done = 1;
        else e_busy = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (running && !rst) begin
      check(rem_out == e_rem, "R2/R3", "rem_out", rem_out, e_rem);
      check(q_out == e_q, "R4", "q_out", q_out, e_q);
      check(t_out == e_t, "R5", "t_out", t_out, e_t);
      check(busy == e_busy && done == e_done, "R6", "busy/done",
            {busy, done}, {e_busy, e_done});
    end
  end

  task automatic launch(input logic [DW-1:0] r, input logic [DW-1:0] d,
                        input bit m, input bit q, input bit t, input int n);
    @(negedge clk);
    rem_in = r; divisor = d; m_in = m; q_in = q; t_in = t;
    step_count = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done) begin
      if (busy) cyc++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rem_out == '0 && !q_out && !t_out && !busy && !done, "R1", "reset",
          {rem_out, q_out, t_out, busy, done}, 0);
    rst = 1'b0;
    running = 1;

    // R2 R3 R4 R5: single steps over every Q/M/T combination
    for (int k = 0; k < 8; k++) begin
      launch(32'hC000_1234 ^ (k * 32'h1111_0000), 32'h4000_0007, k[1], k[0], k[2], 1);
      wait_done(cyc);
      check(cyc == 1, "R6", "one-step busy cycles", cyc, 1);
    end

    // R6: full 32-step chains with assorted flags
    for (int k = 0; k < 6; k++) begin
      launch($urandom, $urandom, k[0], k[1], k[2], 32);
      wait_done(cyc);
      check(cyc == 32, "R6", "32-step busy cycles", cyc, 32);
    end

    // R7: start while busy is ignored
    launch(32'h1234_5678, 32'h0000_9ABC, 0, 0, 0, 10);
    @(negedge clk);
    rem_in = 32'hFFFF_FFFF; divisor = 32'h1; m_in = 1; step_count = CW'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check(cyc == 8, "R7", "busy cycles after ignored start", cyc, 8);

    // R8: zero count loads, no step, immediate done
    launch(32'hDEAD_BEEF, 32'h5, 1, 1, 0, 0);
    check(done && !busy, "R8", "zero-count done", {done, busy}, 2'b10);
    check(rem_out == 32'hDEAD_BEEF, "R8", "zero-count rem", rem_out, 32'hDEAD_BEEF);
    @(negedge clk);
    check(!done, "R8", "done single pulse", done, 0);

    // R10: count above DATA_W clamps
    launch(32'h0F0F_0F0F, 32'h7777_0001, 0, 1, 1, 40);
    wait_done(cyc);
    check(cyc == 32, "R10", "clamped busy cycles", cyc, 32);

    // R9: unsigned quotient extraction
    begin
      logic [31:0] dd [5] = '{32'd100, 32'h0002_FFFF, 32'd1000000, 32'hFFFE_FFFF, 32'd5};
      logic [15:0] dv [5] = '{16'd7, 16'd3, 16'd5000, 16'hFFFF, 16'd9};
      for (int k = 0; k < 5; k++) begin
        logic [15:0] quo, exp;
        launch(dd[k], {dv[k], 16'h0000}, 0, 0, 0, 16);
        wait_done(cyc);
        quo = 16'(((rem_out << 1) | DW'(t_out)));
        exp = 16'(dd[k] / {16'h0, dv[k]});
        check(quo == exp, "R9", "quotient", quo, exp);
      end
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule